// File: doc/BRIEF.md
# Phase-Accumulator Frequency Synthesizer

This block produces a programmable frequency by adding a tuning increment into a 9-bit phase register on every edge of the master clock. The register wraps modulo 512, so its top bit toggles at M·Fc/512. With a 32.768 MHz master clock, this gives integer multiples M of a 64 kHz step, from 64 kHz up to 2.048 MHz. The adder's carry input is forced high, so the 5-bit tuning bus carries M-1. The code 0 selects M = 1 and the code 31 selects M = 32.

The tuning code is captured into an internal register only when a load strobe is high. The increment therefore never changes in the middle of an addition. The block brings out three results. The square wave is the top phase bit, and its edges jitter by up to one master clock period. The full phase word is available to address an external waveform table. An optional built-in sine table, computed at elaboration, is followed by an output register that drives a DAC. A synchronous reset restarts the phase at 0°.

Top module: `phase_accum_synth`

## Requirements
- R1: While `rst` is high at a clock edge, the phase becomes 0, the captured tuning code becomes 0 (M = 1), and `sine_out` becomes 128.
- R2: At each clock edge without reset, the phase becomes (phase + code + 1) mod 512, where code is the captured tuning code.
- R3: A change on `tune` while `load` is low leaves the increment unchanged. The phase keeps advancing by the old code + 1.
- R4: When `load` is high at a clock edge, that edge still adds the old increment. Every later edge adds the newly captured `tune` + 1.
- R5: `sq_out` equals bit 8, the most significant bit, of `phase`.
- R6: `sine_out` is the table value for the phase held one cycle earlier. The table value for phase p is floor(128 + 127.5·sin(2π·p/512)), clamped to 255. Phase 0 maps to 0° and phase 256 maps to 180°.
- R7: With code 31, `sq_out` has a period of 16 clocks. With code 0, its period is 512 clocks.
- R8: The phase wraps modulo 512 with no lost or extra counts across the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture strobe for `tune` |
| tune | input | 5 | Tuning code, equal to M-1 |
| sq_out | output | 1 | Square-wave output (top phase bit) |
| phase | output | 9 | Phase word, 0 = 0°, 256 = 180° |
| sine_out | output | 8 | Registered offset-binary sine sample |

## Verification
The bound checker watches, on every cycle, the phase step, the holding of the captured code when no strobe is present, the capture on a strobe, and the reset values. The checker cannot show the sine values, because they are real-valued. It also cannot show the resulting square-wave period or correct behaviour across many wraps. The bench shows these through its reference model, which it compares every clock, and through explicit period measurements at the two ends of the tuning range.

// File: rtl/phase_accum_synth.sv
`timescale 1ns/1ps
module phase_accum_synth #(
  parameter int ACC_W   = 9,
  parameter int TUNE_W  = 5,
  parameter int SINE_W  = 8,
  parameter bit SINE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TUNE_W-1:0] tune,
  output logic              sq_out,
  output logic [ACC_W-1:0]  phase,
  output logic [SINE_W-1:0] sine_out
);
  localparam int DEPTH = 1 << ACC_W;
  localparam int MID   = 1 << (SINE_W - 1);
  localparam int TOP   = (1 << SINE_W) - 1;

  logic [TUNE_W-1:0] inc_q;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  step;

  assign step = ACC_W'(inc_q) + ACC_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      inc_q <= '0;
    end else begin
      acc <= acc + step;
      if (load) inc_q <= tune;
    end
  end

  assign phase  = acc;
  assign sq_out = acc[ACC_W-1];

  generate
    if (SINE_EN) begin : g_sine
      function automatic logic [SINE_W-1:0] sine_code(input int idx);
        real r;
        int  v;
        r = $sin(6.283185307179586 * real'(idx) / real'(DEPTH));
        v = $rtoi(real'(MID) + (real'(TOP) / 2.0) * r);
        if (v > TOP) v = TOP;
        if (v < 0) v = 0;
        return SINE_W'(v);
      endfunction

      logic [SINE_W-1:0] lut [DEPTH];
      for (genvar g = 0; g < DEPTH; g++) begin : g_lut
        assign lut[g] = sine_code(g);
      end

      logic [SINE_W-1:0] sine_q;
      always_ff @(posedge clk) begin
        if (rst) sine_q <= SINE_W'(MID);
        else     sine_q <= lut[acc];
      end
      assign sine_out = sine_q;
    end else begin : g_nosine
      assign sine_out = '0;
    end
  endgenerate
endmodule

module phase_accum_synth_chk #(
  parameter int ACC_W  = 9,
  parameter int TUNE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [TUNE_W-1:0] tune,
  input logic [ACC_W-1:0]  phase,
  input logic [TUNE_W-1:0] inc_q
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    armed && $past(rst) |-> (phase == '0) && (inc_q == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) |->
      phase == ACC_W'($past(phase) + ACC_W'($past(inc_q)) + ACC_W'(1)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && !$past(load) |-> $stable(inc_q));

  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(load) |-> inc_q == $past(tune));
endmodule

bind phase_accum_synth phase_accum_synth_chk #(.ACC_W(ACC_W), .TUNE_W(TUNE_W)) chk_i (
  .clk(clk), .rst(rst), .load(load), .tune(tune), .phase(phase), .inc_q(inc_q)
);

// File: tb/phase_accum_synth_tb.sv
`timescale 1ns/1ps
module phase_accum_synth_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [4:0] tune = '0;
  logic       sq_out;
  logic [8:0] phase;
  logic [7:0] sine_out;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phase_accum_synth dut_i (
    .clk(clk), .rst(rst), .load(load), .tune(tune),
    .sq_out(sq_out), .phase(phase), .sine_out(sine_out)
  );

  function automatic int sine_ref(input int p);
    real r;
    int  v;
    r = $sin(6.283185307179586 * real'(p) / 512.0);
    v = $rtoi(128.0 + 127.5 * r);
    if (v > 255) v = 255;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int m_acc = 0, m_inc = 0, m_sine = 128;
  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_inc = 0; m_sine = 128;
    end else begin
      m_sine = sine_ref(m_acc);
      m_acc  = (m_acc + m_inc + 1) % 512;
      if (load) m_inc = int'(tune);
    end
  end

  always @(negedge clk) if (!done) begin
    check("R2 phase", int'(phase), m_acc);
    check("R5 sq_out", int'(sq_out), m_acc / 256);
    check("R6 sine_out", int'(sine_out), m_sine);
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input string req, input int exp);
    int cnt;
    logic prev;
    prev = sq_out;
    while (!(prev == 1'b0 && sq_out == 1'b1)) begin prev = sq_out; @(negedge clk); end
    cnt = 0;
    prev = sq_out;
    @(negedge clk); cnt++;
    while (!(prev == 1'b0 && sq_out == 1'b1)) begin prev = sq_out; @(negedge clk); cnt++; end
    check(req, cnt, exp);
  endtask

  initial begin
    int p0, p1;
    run(3);
    check("R1 phase after reset", int'(phase), 0);
    check("R1 sine after reset", int'(sine_out), 128);
    rst = 1'b0;
    run(1);
    check("R1 default step of 1", int'(phase), 1);
    run(20);
    tune = 5'd5; load = 1'b1;
    p0 = int'(phase);
    run(1);
    load = 1'b0;
    check("R4 old increment on load edge", int'(phase), (p0 + 1) % 512);
    p1 = int'(phase);
    run(1);
    check("R4 new increment after load", int'(phase), (p1 + 6) % 512);
    run(600);
    tune = 5'd17;
    p0 = int'(phase);
    run(40);
    check("R3 tune ignored without load", int'(phase), (p0 + 40 * 6) % 512);
    tune = 5'd31; load = 1'b1; run(1); load = 1'b0;
    run(1);
    p0 = int'(phase);
    run(16);
    check("R8 wrap over 16 steps of 32", int'(phase), p0);
    measure("R7 period code 31", 16);
    tune = 5'd0; load = 1'b1; run(1); load = 1'b0;
    measure("R7 period code 0", 512);
    tune = 5'd12; load = 1'b1; run(1); load = 1'b0;
    run(70);
    rst = 1'b1; run(1); rst = 1'b0;
    check("R1 mid-run reset phase", int'(phase), 0);
    check("R1 mid-run reset sine", int'(sine_out), 128);
    run(1);
    check("R1 mid-run reset step", int'(phase), 1);
    run(300);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    #2000000;
    done = 1'b1;
    checks++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule